// File: doc/BRIEF.md
# Pin Pull Resistor Sequencer

This block holds the pull resistor setting of every pin of a general purpose pin bank and lets software change it only through a timed two-step handshake. Software first writes a 2-bit pull code into a single shared mode register. It waits out a setup interval and then raises, in one of the per-bank strobe registers, the bits of the pins that are to take the new code. After a hold interval it clears those bits again. A pin adopts the mode on the write that clears its strobe bit, and only if both intervals were met.

If either interval was too short, or if the mode register was rewritten while the pin's strobe was high, the pin keeps its previous setting and a sticky violation flag is raised. Setup and hold lengths are parameters, counted in clock cycles. The per-pin pull-up and pull-down enables leave the block as registered outputs. The pull setting cannot be read back through the register port.

Top module: `pull_sequencer`

## Requirements
- R1: After reset every pin has its pull-down enable set and its pull-up enable clear, the violation flag is clear, and the mode register holds code 0.
- R2: A write to the mode address (0x94) stores wr_data[1:0]. When a pin adopts a mode, code 0 clears both enables, code 1 sets only the pull-down enable, and code 2 sets only the pull-up enable.
- R3: Code 3 is adopted like code 0: both enables of the pin clear.
- R4: A pin adopts the mode only on a strobe write that changes its bit from 1 to 0. A write that raises the bit leaves the pin's enables unchanged.
- R5: The write that raises a pin's strobe bit must come after at least SETUP_CYCLES idle cycles following the last mode write, or the last reset. With exactly SETUP_CYCLES idle cycles the pin adopts the mode. With one fewer, the pin keeps its setting and the violation flag is set.
- R6: The write that clears a pin's strobe bit must come after at least HOLD_CYCLES idle cycles following the previous write to the same bank's strobe register. With exactly HOLD_CYCLES idle cycles the pin adopts the mode. With one fewer, the pin keeps its setting and the violation flag is set.
- R7: A mode write while a pin's strobe bit is high makes that pin's next clearing write fail: the pin keeps its setting and the violation flag is set.
- R8: Strobe bank b sits at address 0x98 + 4*b, and bit i in it belongs to pin 32*b + i. Pins whose strobe bits do not fall keep their settings. Bits with no pin behind them have no effect.
- R9: Once set, the violation flag stays set until reset, whatever sequences follow.
- R10: No pin ever has its pull-up and pull-down enables set at the same time.
- R11: Writes to addresses other than the mode and strobe registers change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| pull_up_o | output | NUM_PINS | Per-pin pull-up enable |
| pull_dn_o | output | NUM_PINS | Per-pin pull-down enable |
| seq_err_o | output | 1 | Sticky timing violation flag |

## Verification
The assertions assume that the register port has one writer, and that wr_addr and wr_data hold known values whenever wr_en is high. The stimulus meets this by driving every write from one task. Each write lasts one cycle and is followed by counted idle cycles. The stimulus chooses these idle gaps on and beside the setup and hold thresholds, so that both the accepting and the rejecting side of each interval are exercised. It also sometimes rewrites the mode while strobes are high, to reach the mid-handshake corruption case.

// File: rtl/pullseq_pkg.sv
package pullseq_pkg;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2,
    PULL_RSVD = 2'd3
  } pull_mode_e;

  typedef struct packed {
    logic up;
    logic dn;
  } pull_en_t;

  // Reserved code behaves as no pull.
  function automatic pull_en_t mode_to_en(pull_mode_e m);
    pull_en_t e;
    e.up = (m == PULL_UP);
    e.dn = (m == PULL_DOWN);
    return e;
  endfunction

endpackage

// File: rtl/pullseq_timer.sv
// Saturating cycle counter: done once LIMIT cycles passed since the last clr.
module pullseq_timer #(
  parameter int LIMIT = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == LIM);

endmodule

// File: rtl/pullseq_bank.sv
// One strobe register and the pull state of the pins it covers.
module pullseq_bank
  import pullseq_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int HOLD_CYCLES = 150
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bank_wr,
  input  logic [WIDTH-1:0] bank_data,
  input  logic             ctrl_wr,
  input  pull_mode_e       mode,
  input  logic             setup_done,
  output logic [WIDTH-1:0] pu_o,
  output logic [WIDTH-1:0] pd_o,
  output logic             viol_o
);

  logic [WIDTH-1:0] strobe_q;
  logic [WIDTH-1:0] ok_q, ok_d;
  logic [WIDTH-1:0] rise, fall, take, bad;
  logic             hold_done;
  pull_en_t         en;

  pullseq_timer #(.LIMIT(HOLD_CYCLES)) hold_tmr_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (bank_wr),
    .done (hold_done)
  );

  assign en   = mode_to_en(mode);
  assign rise = bank_wr ? (bank_data & ~strobe_q) : '0;
  assign fall = bank_wr ? (~bank_data & strobe_q) : '0;
  assign take = fall & ok_q & {WIDTH{hold_done}};
  assign bad  = fall & ~take;

  always_comb begin
    ok_d = ok_q;
    if (bank_wr) begin
      ok_d = (ok_q & ~rise) | (rise & {WIDTH{setup_done}});
    end
    if (ctrl_wr) begin
      ok_d = ok_d & ~strobe_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= '0;
      ok_q     <= '0;
      pu_o     <= '0;
      pd_o     <= '1;
    end else begin
      if (bank_wr) begin
        strobe_q <= bank_data;
      end
      ok_q <= ok_d;
      pu_o <= (pu_o & ~take) | (take & {WIDTH{en.up}});
      pd_o <= (pd_o & ~take) | (take & {WIDTH{en.dn}});
    end
  end

  assign viol_o = |bad;

endmodule

// File: rtl/pull_sequencer.sv
module pull_sequencer
  import pullseq_pkg::*;
#(
  parameter int NUM_PINS     = 54,
  parameter int SETUP_CYCLES = 150,
  parameter int HOLD_CYCLES  = 150,
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32,
  parameter int CTRL_ADDR    = 'h94,
  parameter int STROBE_BASE  = 'h98
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_PINS-1:0] pull_up_o,
  output logic [NUM_PINS-1:0] pull_dn_o,
  output logic                seq_err_o
);

  localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int WORD_B    = DATA_W / 8;

  pull_mode_e           mode_q;
  logic                 ctrl_wr;
  logic                 setup_done;
  logic [NUM_BANKS-1:0] viol;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PULL_NONE;
    end else if (ctrl_wr) begin
      mode_q <= pull_mode_e'(wr_data[1:0]);
    end
  end

  pullseq_timer #(.LIMIT(SETUP_CYCLES)) setup_tmr_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (ctrl_wr),
    .done (setup_done)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LEFT = NUM_PINS - b * DATA_W;
    localparam int W    = (LEFT > DATA_W) ? DATA_W : LEFT;
    logic bank_wr;

    assign bank_wr = wr_en && (wr_addr == ADDR_W'(STROBE_BASE + b * WORD_B));

    pullseq_bank #(
      .WIDTH       (W),
      .HOLD_CYCLES (HOLD_CYCLES)
    ) bank_i (
      .clk        (clk),
      .rst        (rst),
      .bank_wr    (bank_wr),
      .bank_data  (wr_data[W-1:0]),
      .ctrl_wr    (ctrl_wr),
      .mode       (mode_q),
      .setup_done (setup_done),
      .pu_o       (pull_up_o[b*DATA_W +: W]),
      .pd_o       (pull_dn_o[b*DATA_W +: W]),
      .viol_o     (viol[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_err_o <= 1'b0;
    end else if (|viol) begin
      seq_err_o <= 1'b1;
    end
  end

endmodule

// File: rtl/pull_sequencer_chk.sv
module pull_sequencer_chk #(
  parameter int NUM_PINS  = 54,
  parameter int ADDR_W    = 8,
  parameter int CTRL_ADDR = 'h94
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [NUM_PINS-1:0] pull_up_o,
  input logic [NUM_PINS-1:0] pull_dn_o,
  input logic                seq_err_o
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pull_dn_o == {NUM_PINS{1'b1}}) && (pull_up_o == '0) && !seq_err_o);

  assert_no_conflict_R10: assert property (@(posedge clk) disable iff (rst)
    (pull_up_o & pull_dn_o) == '0);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    seq_err_o |=> seq_err_o);

  assert_err_needs_write_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_err_o) |-> $past(wr_en));

  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(pull_up_o) && $stable(pull_dn_o)));

  assert_mode_write_no_apply_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) |=> ($stable(pull_up_o) && $stable(pull_dn_o)));

endmodule

bind pull_sequencer pull_sequencer_chk #(
  .NUM_PINS  (NUM_PINS),
  .ADDR_W    (ADDR_W),
  .CTRL_ADDR (CTRL_ADDR)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .pull_up_o (pull_up_o),
  .pull_dn_o (pull_dn_o),
  .seq_err_o (seq_err_o)
);

// File: tb/pull_sequencer_tb_top.sv
module pull_sequencer_tb_top;
  localparam int N  = 54;
  localparam int SU = 150;
  localparam int HO = 150;
  localparam int NB = 2;
  localparam logic [7:0] A_CTRL = 8'h94;
  localparam logic [7:0] A_B0   = 8'h98;
  localparam logic [7:0] A_B1   = 8'h9C;
  localparam logic [7:0] A_BAD  = 8'hA4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [N-1:0] pu, pd;
  logic         err;

  always #2 clk = ~clk;

  pull_sequencer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pull_up_o(pu), .pull_dn_o(pd), .seq_err_o(err)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [N-1:0] m_pu, m_pd, m_clk, m_ok;
  logic         m_err;
  logic [1:0]   m_mode;
  int           last_ctrl;
  int           last_bank [NB];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "pull_up", 64'(pu), 64'(m_pu));
    chk(tag, "pull_dn", 64'(pd), 64'(m_pd));
    chk(tag, "err", 64'(err), 64'(m_err));
  endtask

  task automatic model_write(logic [7:0] a, logic [31:0] d);
    if (a == A_CTRL) begin
      m_ok = m_ok & ~m_clk;
      m_mode = d[1:0];
      last_ctrl = cyc;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (int'(a) == int'(A_B0) + 4 * b) begin
          for (int i = 0; i < 32; i++) begin
            int p;
            p = b * 32 + i;
            if (p < N) begin
              if (d[i] && !m_clk[p]) m_ok[p] = ((cyc - last_ctrl - 1) >= SU);
              if (!d[i] && m_clk[p]) begin
                if (m_ok[p] && ((cyc - last_bank[b] - 1) >= HO)) begin
                  m_pu[p] = (m_mode == 2'd2);
                  m_pd[p] = (m_mode == 2'd1);
                end else begin
                  m_err = 1'b1;
                end
              end
              m_clk[p] = d[i];
            end
          end
          last_bank[b] = cyc;
        end
      end
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    cyc++;
    model_write(a, d);
    #1;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      @(posedge clk);
      cyc++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      cyc++;
    end
    m_pu = '0; m_pd = '1; m_clk = '0; m_ok = '0; m_err = 1'b0; m_mode = 2'd0;
    last_ctrl = cyc;
    for (int b = 0; b < NB; b++) last_bank[b] = cyc;
    #1 rst = 1'b0;
  endtask

  task automatic seq(string tag, int b, logic [31:0] mask, logic [1:0] code, int sg, int hg);
    logic [7:0] a;
    a = (b == 0) ? A_B0 : A_B1;
    wr(A_CTRL, {30'd0, code});
    idle(sg);
    wr(a, mask);
    compare(tag);
    idle(hg);
    wr(a, 32'd0);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    do_reset();
    idle(1);
    // R1 reset state
    compare("R1");
    chk("R1", "pin0 dn", 64'(pd[0]), 64'd1);

    // R2/R4 pull-up on pin 3 via proper sequence
    seq("R4", 0, 32'h8, 2'd2, SU, HO);
    chk("R2", "pin3 up", 64'(pu[3]), 64'd1);
    chk("R2", "pin3 dn", 64'(pd[3]), 64'd0);
    // R2 code 0 and code 1; R8 bank 1 pin 40
    seq("R2", 1, 32'h100, 2'd0, SU, HO);
    chk("R8", "pin40 none", 64'({pu[40], pd[40]}), 64'd0);
    seq("R2", 1, 32'h100, 2'd1, SU + 3, HO + 7);
    chk("R2", "pin40 dn", 64'(pd[40]), 64'd1);
    // R3 code 3
    seq("R3", 0, 32'h30, 2'd3, SU, HO);
    chk("R3", "pins5:4", 64'({pu[5:4], pd[5:4]}), 64'd0);
    // R8 bits with no pin behind them
    seq("R8", 1, 32'hFFC0_0000, 2'd2, SU, HO);
    chk("R8", "no change err", 64'(err), 64'd0);
    // R11 unmapped address
    wr(A_BAD, 32'hFFFF_FFFF);
    idle(2);
    compare("R11");
    // R5 setup one short
    seq("R5", 0, 32'h1, 2'd2, SU - 1, HO);
    chk("R5", "pin0 kept", 64'(pu[0]), 64'd0);
    chk("R5", "err", 64'(err), 64'd1);
    // R9 sticky across good sequence
    seq("R9", 0, 32'h2, 2'd2, SU, HO);
    chk("R9", "err stays", 64'(err), 64'd1);

    do_reset();
    // R6 hold one short, then exact
    seq("R6", 0, 32'h4, 2'd2, SU, HO - 1);
    chk("R6", "pin2 kept", 64'(pd[2]), 64'd1);
    do_reset();
    seq("R6", 0, 32'h4, 2'd2, SU, HO);
    chk("R6", "pin2 up", 64'(pu[2]), 64'd1);
    chk("R6", "err clear", 64'(err), 64'd0);

    // R7 mode rewrite while strobe high
    do_reset();
    wr(A_CTRL, 32'd2);
    idle(SU);
    wr(A_B0, 32'h80);
    idle(10);
    wr(A_CTRL, 32'd0);
    idle(HO);
    wr(A_B0, 32'd0);
    compare("R7");
    chk("R7", "pin7 kept", 64'(pd[7]), 64'd1);

    // Random phase
    do_reset();
    for (int it = 0; it < 40; it++) begin
      int b, sg, hg, pick;
      logic [31:0] mask;
      logic [1:0] code;
      b = int'($urandom % 2);
      mask = $urandom;
      code = 2'($urandom % 4);
      pick = int'($urandom % 4);
      sg = (pick == 0) ? SU - 1 : (pick == 1) ? SU : SU + 4;
      pick = int'($urandom % 4);
      hg = (pick == 0) ? HO - 1 : (pick == 1) ? HO : HO + 2;
      if (($urandom % 8) == 0) begin
        wr(A_CTRL, {30'd0, code});
        idle(sg);
        wr((b == 0) ? A_B0 : A_B1, mask);
        idle(5);
        wr(A_CTRL, 32'd1);
        idle(hg);
        wr((b == 0) ? A_B0 : A_B1, 32'd0);
        compare("R7");
      end else begin
        seq("R5", b, mask, code, sg, hg);
      end
      chk("R10", "overlap", 64'(pu & pd), 64'd0);
      if (($urandom % 10) == 0) do_reset();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule